// File: doc/BRIEF.md
# Two-Cycle Memory Command Issuer

This block turns controller-side memory requests into command-bus activity for a DDR3-style device. It runs on the double-rate address/command clock. Each command takes a slot two clock cycles long. The row/column strobes, write enable, bank and address lines are driven for the whole slot. Chip select, clock enable and on-die termination change only at the point where a slot enters its second cycle. This lets the lines settle before the device samples them, and it still allows one command in every slot with no gap.

Requests use a valid/ready handshake. A request carries an operation code, a bank, an address, a run length, a stride and a termination flag. A read or write with a run length above one starts the burst helper. The helper then issues that many column commands back to back, with the address stepping by the stride each time. When no request is accepted, the slot is a deselect: chip select stays high, the lines show the no-operation pattern, and bank and address are zero.

After reset, clock enable stays low for a programmable number of cycles. No request is accepted until it goes high.

Top module: `ddr_cmd2t_seq`

## Requirements
- R1: While reset is high and in the cycle after it is released, the pins are cs_n=1, cke=0, odt=0, {ras_n,cas_n,we_n}=111, bank 0, address 0, and req_ready=0.
- R2: ras_n, cas_n, we_n, bank and address change only when a new slot begins. In the cycle where cs_n is low, they equal their values of the cycle before.
- R3: cs_n goes low only in the second cycle of a slot that carries an accepted command. A slot with no accepted command keeps cs_n high in both cycles and shows lines 111, bank 0 and address 0.
- R4: Commands accepted back to back give cs_n low pulses exactly two cycles apart, with cs_n high between them. cs_n is never low in two consecutive cycles.
- R5: req_op is mapped to {ras_n,cas_n,we_n} as follows: 0 no-op gives 111, 1 activate gives 011, 2 read gives 101, 3 write gives 100, 4 precharge gives 010. Codes 5 to 7 are issued as a no-op, which is 111 with cs_n low.
- R6: req_ready is high only in the second cycle of a slot, and only while cke is high and no burst is running. An accepted request is on the lines from the next cycle, and cs_n goes low one cycle after that.
- R7: A read (2) or write (3) with req_len above 1 issues req_len commands in consecutive slots to the same bank. The k-th command uses address req_addr + k*req_stride modulo 2^ADDR_W. req_ready stays low until the last one is issued. A req_len of 0 or 1, or any other operation, issues one command.
- R8: cke rises only when a slot enters its second cycle, and never before INIT_CYC cycles have passed after reset. Once high, it stays high until the next reset.
- R9: odt takes the termination flag of the current slot when the slot enters its second cycle. A burst keeps the flag of its request, and slots with no command drive 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate address/command clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at the next edge when valid |
| req_op | input | 3 | Operation code (see R5) |
| req_bank | input | BA_W | Bank |
| req_addr | input | ADDR_W | Row or start column address |
| req_len | input | LEN_W | Number of column commands in a run |
| req_stride | input | STRIDE_W | Address step between run commands |
| req_odt | input | 1 | Termination flag for the request's slots |
| ca_ras_n | output | 1 | Row strobe, active low |
| ca_cas_n | output | 1 | Column strobe, active low |
| ca_we_n | output | 1 | Write enable, active low |
| ca_cs_n | output | 1 | Chip select, active low |
| ca_cke | output | 1 | Clock enable |
| ca_odt | output | 1 | On-die termination |
| ca_ba | output | BA_W | Bank address |
| ca_addr | output | ADDR_W | Address |

## Verification
The bound checker covers the timing rules that hold in every cycle. These are: the command lines held while chip select is low, chip select only in a second cycle and never twice in a row, ready only in a second cycle with clock enable high, clock enable staying high, and termination and clock enable changing only at the mid-slot point. The directed scenarios cover the parts that depend on content: the line pattern for each operation code, address stepping and wrap-around in a run, exact slot spacing when commands arrive back to back, the return to a zero-address deselect, and the length of the clock-enable delay.

// File: rtl/ddr_cmd2t_pkg.sv
package ddr_cmd2t_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4
  } op_e;

  // {ras_n, cas_n, we_n} for an operation code; unknown codes map to no-op
  function automatic logic [2:0] op_lines(input logic [2:0] op);
    case (op)
      OP_ACT:  return 3'b011;
      OP_RD:   return 3'b101;
      OP_WR:   return 3'b100;
      OP_PRE:  return 3'b010;
      default: return 3'b111;
    endcase
  endfunction

  function automatic logic is_column(input logic [2:0] op);
    return (op == OP_RD) || (op == OP_WR);
  endfunction

endpackage

// File: rtl/ddr_cmd2t_slot.sv
// Slot phase and clock-enable delay counter
module ddr_cmd2t_slot #(
  parameter int INIT_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tail_q,     // bus is in the second cycle of a slot
  output logic init_done
);
  localparam int CW = $clog2(INIT_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tail_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      tail_q <= ~tail_q;
      if (cnt_q != CW'(INIT_CYC)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign init_done = (cnt_q == CW'(INIT_CYC));

endmodule

// File: rtl/ddr_cmd2t_burst.sv
// Run generator for consecutive column commands
module ddr_cmd2t_burst #(
  parameter int BA_W     = 3,
  parameter int ADDR_W   = 14,
  parameter int LEN_W    = 4,
  parameter int STRIDE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              advance,
  input  logic [2:0]        op_in,
  input  logic [BA_W-1:0]   ba_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [LEN_W-1:0]  len_in,
  input  logic [STRIDE_W-1:0] stride_in,
  input  logic              odt_in,
  output logic              busy,
  output logic [2:0]        op_out,
  output logic [BA_W-1:0]   ba_out,
  output logic [ADDR_W-1:0] addr_out,
  output logic              odt_out
);
  logic [LEN_W-1:0]    rem_q;
  logic [ADDR_W-1:0]   stride_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      rem_q    <= '0;
      stride_q <= '0;
      op_out   <= '0;
      ba_out   <= '0;
      addr_out <= '0;
      odt_out  <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      rem_q    <= len_in - 1'b1;
      stride_q <= ADDR_W'(stride_in);
      op_out   <= op_in;
      ba_out   <= ba_in;
      addr_out <= addr_in + ADDR_W'(stride_in);
      odt_out  <= odt_in;
    end else if (advance && busy) begin
      addr_out <= addr_out + stride_q;
      rem_q    <= rem_q - 1'b1;
      if (rem_q == LEN_W'(1)) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/ddr_cmd2t_pins.sv
// Registered command pins: lines load at slot start, strobes at mid-slot
module ddr_cmd2t_pins #(
  parameter int BA_W   = 3,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              live,
  input  logic [2:0]        lines,
  input  logic [BA_W-1:0]   ba_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              odt_in,
  input  logic              cke_ok,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              cs_n,
  output logic              cke,
  output logic              odt,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);
  logic live_q, odt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      {ras_n, cas_n, we_n} <= 3'b111;
      cs_n   <= 1'b1;
      cke    <= 1'b0;
      odt    <= 1'b0;
      ba     <= '0;
      addr   <= '0;
      live_q <= 1'b0;
      odt_q  <= 1'b0;
    end else if (load) begin
      {ras_n, cas_n, we_n} <= lines;
      ba     <= ba_in;
      addr   <= addr_in;
      live_q <= live;
      odt_q  <= odt_in;
      cs_n   <= 1'b1;
    end else begin
      cs_n <= ~live_q;
      odt  <= odt_q;
      cke  <= cke_ok;
    end
  end

endmodule

// File: rtl/ddr_cmd2t_seq.sv
module ddr_cmd2t_seq
  import ddr_cmd2t_pkg::*;
#(
  parameter int BA_W     = 3,
  parameter int ADDR_W   = 14,
  parameter int LEN_W    = 4,
  parameter int STRIDE_W = 4,
  parameter int INIT_CYC = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [2:0]          req_op,
  input  logic [BA_W-1:0]     req_bank,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [LEN_W-1:0]    req_len,
  input  logic [STRIDE_W-1:0] req_stride,
  input  logic                req_odt,
  output logic                ca_ras_n,
  output logic                ca_cas_n,
  output logic                ca_we_n,
  output logic                ca_cs_n,
  output logic                ca_cke,
  output logic                ca_odt,
  output logic [BA_W-1:0]     ca_ba,
  output logic [ADDR_W-1:0]   ca_addr
);
  logic              tail_q, init_done, accept, run_start, busy;
  logic [2:0]        b_op;
  logic [BA_W-1:0]   b_ba;
  logic [ADDR_W-1:0] b_addr;
  logic              b_odt;

  logic              s_live, s_odt;
  logic [2:0]        s_lines;
  logic [BA_W-1:0]   s_ba;
  logic [ADDR_W-1:0] s_addr;

  ddr_cmd2t_slot #(.INIT_CYC(INIT_CYC)) slot_i (
    .clk(clk), .rst(rst), .tail_q(tail_q), .init_done(init_done)
  );

  assign req_ready = tail_q & ca_cke & ~busy;
  assign accept    = req_valid & req_ready;
  assign run_start = accept & is_column(req_op) & (req_len > LEN_W'(1));

  ddr_cmd2t_burst #(
    .BA_W(BA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .STRIDE_W(STRIDE_W)
  ) burst_i (
    .clk(clk), .rst(rst), .start(run_start), .advance(tail_q),
    .op_in(req_op), .ba_in(req_bank), .addr_in(req_addr), .len_in(req_len),
    .stride_in(req_stride), .odt_in(req_odt),
    .busy(busy), .op_out(b_op), .ba_out(b_ba), .addr_out(b_addr), .odt_out(b_odt)
  );

  always_comb begin
    if (busy) begin
      s_live = 1'b1; s_lines = op_lines(b_op);
      s_ba = b_ba;   s_addr = b_addr; s_odt = b_odt;
    end else if (accept) begin
      s_live = 1'b1; s_lines = op_lines(req_op);
      s_ba = req_bank; s_addr = req_addr; s_odt = req_odt;
    end else begin
      s_live = 1'b0; s_lines = 3'b111;
      s_ba = '0;     s_addr = '0;     s_odt = 1'b0;
    end
  end

  ddr_cmd2t_pins #(.BA_W(BA_W), .ADDR_W(ADDR_W)) pins_i (
    .clk(clk), .rst(rst), .load(tail_q), .live(s_live), .lines(s_lines),
    .ba_in(s_ba), .addr_in(s_addr), .odt_in(s_odt), .cke_ok(init_done),
    .ras_n(ca_ras_n), .cas_n(ca_cas_n), .we_n(ca_we_n), .cs_n(ca_cs_n),
    .cke(ca_cke), .odt(ca_odt), .ba(ca_ba), .addr(ca_addr)
  );

endmodule

// File: rtl/ddr_cmd2t_chk.sv
module ddr_cmd2t_chk #(
  parameter int BA_W   = 3,
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              tail_q,
  input logic              req_ready,
  input logic              ca_ras_n,
  input logic              ca_cas_n,
  input logic              ca_we_n,
  input logic              ca_cs_n,
  input logic              ca_cke,
  input logic              ca_odt,
  input logic [BA_W-1:0]   ca_ba,
  input logic [ADDR_W-1:0] ca_addr
);
  AST_LINES_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ca_cs_n |-> $stable({ca_ras_n, ca_cas_n, ca_we_n, ca_ba, ca_addr})); // R2
  AST_CS_LATE: assert property (@(posedge clk) disable iff (rst)
    !ca_cs_n |-> tail_q); // R3
  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (rst)
    !ca_cs_n |=> ca_cs_n); // R4
  AST_READY_SLOT: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (tail_q && ca_cke)); // R6
  AST_CKE_STAYS: assert property (@(posedge clk) disable iff (rst)
    ca_cke |=> ca_cke); // R8
  AST_CKE_LATE: assert property (@(posedge clk) disable iff (rst)
    $rose(ca_cke) |-> tail_q); // R8
  AST_ODT_LATE: assert property (@(posedge clk) disable iff (rst)
    !$stable(ca_odt) |-> tail_q); // R9
endmodule

bind ddr_cmd2t_seq ddr_cmd2t_chk #(.BA_W(BA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .tail_q(tail_q), .req_ready(req_ready),
  .ca_ras_n(ca_ras_n), .ca_cas_n(ca_cas_n), .ca_we_n(ca_we_n),
  .ca_cs_n(ca_cs_n), .ca_cke(ca_cke), .ca_odt(ca_odt),
  .ca_ba(ca_ba), .ca_addr(ca_addr)
);

// File: tb/ddr_cmd2t_seq_tb_top.sv
`timescale 1ns/1ps
module ddr_cmd2t_seq_tb_top;
  localparam int BA_W = 3, ADDR_W = 14, LEN_W = 4, STRIDE_W = 4, INIT_CYC = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_ready, req_odt = 1'b0;
  logic [2:0] req_op = '0;
  logic [BA_W-1:0] req_bank = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [STRIDE_W-1:0] req_stride = '0;
  logic ca_ras_n, ca_cas_n, ca_we_n, ca_cs_n, ca_cke, ca_odt;
  logic [BA_W-1:0] ca_ba;
  logic [ADDR_W-1:0] ca_addr;

  always #4 clk = ~clk;

  ddr_cmd2t_seq #(.BA_W(BA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
                  .STRIDE_W(STRIDE_W), .INIT_CYC(INIT_CYC)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_bank(req_bank), .req_addr(req_addr), .req_len(req_len),
    .req_stride(req_stride), .req_odt(req_odt),
    .ca_ras_n(ca_ras_n), .ca_cas_n(ca_cas_n), .ca_we_n(ca_we_n), .ca_cs_n(ca_cs_n),
    .ca_cke(ca_cke), .ca_odt(ca_odt), .ca_ba(ca_ba), .ca_addr(ca_addr)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // bus monitor: logs every cycle with chip select low
  int lg_n = 0, ncyc = 0, hold_err = 0, dbl_err = 0;
  int lg_lines[64], lg_ba[64], lg_addr[64], lg_cyc[64], lg_odt[64];
  logic [2+BA_W+ADDR_W:0] prev_bus;
  logic prev_cs = 1'b1;

  always @(negedge clk) begin
    if (rst) begin
      ncyc = 0;
      prev_cs = 1'b1;
    end else begin
      ncyc++;
      if (!ca_cs_n) begin
        if (prev_bus != {ca_ras_n, ca_cas_n, ca_we_n, ca_ba, ca_addr}) hold_err++;
        if (!prev_cs) dbl_err++;
        if (lg_n < 64) begin
          lg_lines[lg_n] = {29'd0, ca_ras_n, ca_cas_n, ca_we_n};
          lg_ba[lg_n] = int'(ca_ba);
          lg_addr[lg_n] = int'(ca_addr);
          lg_cyc[lg_n] = ncyc;
          lg_odt[lg_n] = int'(ca_odt);
          lg_n++;
        end
      end
      prev_cs = ca_cs_n;
    end
    prev_bus = {ca_ras_n, ca_cas_n, ca_we_n, ca_ba, ca_addr};
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input int op, input int ba, input int addr, input int len,
                      input int stride, input bit odt);
    bit r;
    req_op = 3'(op); req_bank = BA_W'(ba); req_addr = ADDR_W'(addr);
    req_len = LEN_W'(len); req_stride = STRIDE_W'(stride); req_odt = odt;
    req_valid = 1'b1;
    for (int i = 0; i < 100; i++) begin
      r = req_ready;
      @(negedge clk);
      if (r) break;
    end
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    idle(3);
    chk("R1 cs_n", int'(ca_cs_n), 1);
    chk("R1 cke", int'(ca_cke), 0);
    chk("R1 odt", int'(ca_odt), 0);
    chk("R1 lines", int'({ca_ras_n, ca_cas_n, ca_we_n}), 7);
    chk("R1 addr/ba", int'(ca_addr) + int'(ca_ba), 0);
    chk("R1 ready", int'(req_ready), 0);
    rst = 1'b0;
    idle(1);
    chk("R1 cs_n after release", int'(ca_cs_n), 1);
    chk("R1 ready after release", int'(req_ready), 0);
  endtask

  task automatic t_cke();
    idle(6);               // seven edges since release
    chk("R8 cke still low", int'(ca_cke), 0);
    chk("R6 ready while cke low", int'(req_ready), 0);
    idle(4);               // eleven edges
    chk("R8 cke high", int'(ca_cke), 1);
    idle(5);
    chk("R8 cke stays high", int'(ca_cke), 1);
  endtask

  task automatic t_seq();
    int b = lg_n;
    int h = hold_err;
    send(0, 0, 0, 0, 0, 0);
    send(4, 0, 'h400, 0, 0, 0);
    send(1, 3, 'h1234, 0, 0, 0);
    send(3, 3, 'h10, 0, 0, 1);
    idle(6);
    chk("R3 command count", lg_n - b, 4);
    chk("R5 nop lines", lg_lines[b], 7);
    chk("R5 pre lines", lg_lines[b+1], 2);
    chk("R5 act lines", lg_lines[b+2], 3);
    chk("R5 wr lines", lg_lines[b+3], 4);
    chk("R5 act addr", lg_addr[b+2], 'h1234);
    chk("R5 act bank", lg_ba[b+2], 3);
    for (int i = 1; i < 4; i++) chk("R4 spacing", lg_cyc[b+i] - lg_cyc[b+i-1], 2);
    chk("R9 odt on write", lg_odt[b+3], 1);
    chk("R9 odt on act", lg_odt[b+2], 0);
    chk("R2 hold", hold_err - h, 0);
    chk("R3 idle lines", int'({ca_ras_n, ca_cas_n, ca_we_n}), 7);
    chk("R3 idle addr", int'(ca_addr), 0);
    chk("R3 idle cs_n", int'(ca_cs_n), 1);
    chk("R9 idle odt", int'(ca_odt), 0);
  endtask

  task automatic t_burst_wr();
    int b = lg_n;
    int bad = 0;
    send(3, 2, 0, 5, 4, 1);
    for (int i = 0; i < 9; i++) begin
      if (req_ready) bad++;
      @(negedge clk);
    end
    chk("R7 ready low during run", bad, 0);
    chk("R6 ready after run", int'(req_ready), 1);
    idle(6);
    chk("R7 run count", lg_n - b, 5);
    for (int k = 0; k < 5; k++) begin
      chk("R7 run addr", lg_addr[b+k], 4*k);
      chk("R7 run bank", lg_ba[b+k], 2);
      chk("R5 run lines", lg_lines[b+k], 4);
      chk("R9 run odt", lg_odt[b+k], 1);
      if (k > 0) chk("R4 run spacing", lg_cyc[b+k] - lg_cyc[b+k-1], 2);
    end
    chk("R3 back to nop addr 0", int'(ca_addr), 0);
    chk("R9 odt drops", int'(ca_odt), 0);
  endtask

  task automatic t_burst_wrap();
    int b = lg_n;
    send(2, 1, 'h3FF8, 3, 8, 0);
    send(4, 1, 0, 0, 0, 0);
    idle(6);
    chk("R7 wrap count", lg_n - b, 4);
    chk("R7 wrap addr0", lg_addr[b], 'h3FF8);
    chk("R7 wrap addr1", lg_addr[b+1], 0);
    chk("R7 wrap addr2", lg_addr[b+2], 8);
    chk("R5 read lines", lg_lines[b], 5);
    chk("R4 pre follows run", lg_cyc[b+3] - lg_cyc[b+2], 2);
    chk("R5 pre after run", lg_lines[b+3], 2);
  endtask

  task automatic t_odd();
    int b = lg_n;
    send(5, 0, 'h55, 0, 0, 0);
    send(1, 4, 'h77, 7, 1, 0);
    send(3, 0, 'h20, 0, 4, 0);
    idle(8);
    chk("R7 single count", lg_n - b, 3);
    chk("R5 code5 as nop", lg_lines[b], 7);
    chk("R7 act ignores len", lg_addr[b+1], 'h77);
    chk("R7 len0 single", lg_addr[b+2], 'h20);
    chk("R4 no double cs", dbl_err, 0);
    chk("R2 hold all", hold_err, 0);
  endtask

  initial begin
    idle(1);
    t_reset();
    t_cke();
    t_seq();
    t_burst_wr();
    t_burst_wrap();
    t_odd();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule